// File: doc/BRIEF.md
# SDRAM Word-Access Controller

This block connects a CPU-side word port to a 32 MiB SDRAM device with a 16-bit data bus. After reset it brings the device up and programs its mode register for CAS latency 2 and a burst of two. From then on it serves one 32-bit word for each CPU request. Each word travels as two 16-bit beats inside a single burst. After the access the row is closed and the controller goes back to idle. Auto-refresh commands are scheduled internally, and the CPU plays no part in them.

The CPU sees a word address, write data, read data, a request strobe, a write enable and a busy flag. Busy is released as soon as the read word is assembled or the second write beat has been handed to the device. It does not wait for the row to be closed. A request that arrives while the controller is still closing a row or refreshing is latched and served once the sequencer is back in idle. Memory contents survive a controller reset.

Top module: `sdram_word_ctrl`

## Requirements
- R1: From reset until initialization ends, busy stays high. During that time the first four commands issued are, in order: precharge-all (address bit 10 high), auto-refresh, auto-refresh, and mode-register load with address 0x021 (burst length code 001 in bits 2:0, CAS latency 2 as 010 in bits 6:4, all other bits zero).
- R2: The 23-bit word address maps as follows: bits 22:21 select the bank, bits 20:8 the row, and the device column is {address bits 7:0, 0}. The word therefore occupies two consecutive 16-bit locations of the device's 16 Mi × 16 space.
- R3: The low half of the word (bits 15:0) travels on the first beat at the even column and the high half on the second beat. Both data-mask bits are low on both write beats, and the data-bus enable is high on exactly those two beats.
- R4: Every access is one activate, then one read or write (address bit 10 low) issued at least T_RCD cycles after the activate, then a precharge of that bank. No activate reaches a bank sooner than T_RP cycles after its precharge.
- R5: Busy falls on the clock edge after the second write beat has been driven, or on the edge that captures the high read half, while the row is still open.
- R6: A request is taken only when busy is low. A strobe raised while busy is high is ignored. A request taken during the row-closing tail is held and served after the precharge.
- R7: After initialization the controller issues an auto-refresh about every REF_INTERVAL cycles on its own, with all banks closed and at least T_RFC cycles before the next command.
- R8: When a refresh is due and a CPU request is waiting in idle, the refresh is issued first.
- R9: A reset does not write to memory. Words written before a reset read back unchanged after it.
- R10: A read returns the word most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, sampled when busy is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 23 | Word address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Last word read |
| cpu_busy | output | 1 | High while initializing or serving a request |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Row / column / mode address |
| sd_dqm | output | 2 | Byte data masks (held low) |
| sd_dq_o | output | 16 | Data toward the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_o |
| sd_dq_i | input | 16 | Data from the device |

## Verification
Two functions can fall in the same cycle. A refresh can come due while a CPU request is waiting in idle, and a fresh CPU request can arrive while the previous access is still closing its row. The bench provokes both with long back-to-back streams of accesses spread over many refresh intervals, and with a new request issued on the very edge where busy drops. A behavioural device model judges every command edge: bank state, spacing, refresh gaps and the mode setting. Every returned word is compared with a reference memory kept in the bench.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int BANK_W  = 2;
    localparam int ROW_W   = 13;
    localparam int COL_W   = 9;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int WA_W    = BANK_W + ROW_W + COL_W - 1;
    localparam int CAS_LAT = 2;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        C_NOP = 3'b111,
        C_ACT = 3'b011,
        C_RD  = 3'b101,
        C_WR  = 3'b100,
        C_PRE = 3'b010,
        C_REF = 3'b001,
        C_MRS = 3'b000
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        S_PWR, S_IPRE, S_IREF, S_IMRS,
        S_IDLE, S_REF, S_ACT,
        S_WR1, S_WR2, S_WREC,
        S_RD, S_RD2, S_PRE
    } sdr_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } sdr_loc_t;

    typedef struct packed {
        logic              we;
        logic [WA_W-1:0]   addr;
        logic [WORD_W-1:0] data;
    } sdr_req_t;

    function automatic sdr_loc_t map_word(input logic [WA_W-1:0] wa);
        sdr_loc_t l;
        l.bank = wa[WA_W-1 -: BANK_W];
        l.row  = wa[COL_W-1 +: ROW_W];
        l.col  = {wa[COL_W-2:0], 1'b0};
        return l;
    endfunction

    // sequential burst of two, CAS latency 2, burst writes
    function automatic logic [ROW_W-1:0] mode_word();
        logic [ROW_W-1:0] m;
        m      = '0;
        m[2:0] = 3'b001;
        m[6:4] = 3'(CAS_LAT);
        return m;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pending
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;
    logic         tick;

    assign tick = (cnt == W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

    // R7: a due refresh stays flagged until the sequencer takes it
    a_r7_pending_held: assert property (@(posedge clk) disable iff (rst || !en)
        (pending && !ack) |=> pending);

endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
    import sdr_pkg::*;
#(
    parameter int T_INIT    = 20,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 4,
    parameter int T_RCD     = 2,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int INIT_REFS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WA_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_busy,
    input  logic              ref_pend,
    output logic              ref_ack,
    output logic              init_done,
    output sdr_cmd_e          cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  a,
    output logic [HALF_W-1:0] dq_o,
    output logic              dq_oe,
    input  logic [HALF_W-1:0] dq_i
);
    localparam int CNT_W = $clog2(T_INIT + T_RP + T_RFC + T_RCD + T_WR + T_MRD + 8);
    localparam int NR_W  = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] PRE_ALL = ROW_W'(1) << 10;

    sdr_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [NR_W-1:0]   nref;
    logic              pend;
    sdr_req_t          req;
    logic [HALF_W-1:0] lo;
    sdr_loc_t          loc;
    logic              tick;

    assign loc  = map_word(req.addr);
    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_PWR;
            cnt       <= CNT_W'(T_INIT - 1);
            nref      <= '0;
            cmd       <= C_NOP;
            ba        <= '0;
            a         <= '0;
            dq_o      <= '0;
            dq_oe     <= 1'b0;
            cpu_busy  <= 1'b1;
            cpu_rdata <= '0;
            pend      <= 1'b0;
            req       <= '0;
            lo        <= '0;
            ref_ack   <= 1'b0;
            init_done <= 1'b0;
        end else begin
            cmd     <= C_NOP;
            ref_ack <= 1'b0;
            if (!tick) cnt <= cnt - 1'b1;

            if (cpu_req && !cpu_busy) begin
                req      <= '{we: cpu_we, addr: cpu_addr, data: cpu_wdata};
                pend     <= 1'b1;
                cpu_busy <= 1'b1;
            end

            case (state)
                S_PWR: if (tick) begin
                    cmd   <= C_PRE;
                    a     <= PRE_ALL;
                    cnt   <= CNT_W'(T_RP - 1);
                    state <= S_IPRE;
                end
                S_IPRE: if (tick) begin
                    cmd   <= C_REF;
                    nref  <= NR_W'(1);
                    cnt   <= CNT_W'(T_RFC - 1);
                    state <= S_IREF;
                end
                S_IREF: if (tick) begin
                    if (nref < NR_W'(INIT_REFS)) begin
                        cmd  <= C_REF;
                        nref <= nref + 1'b1;
                        cnt  <= CNT_W'(T_RFC - 1);
                    end else begin
                        cmd   <= C_MRS;
                        ba    <= '0;
                        a     <= mode_word();
                        cnt   <= CNT_W'(T_MRD - 1);
                        state <= S_IMRS;
                    end
                end
                S_IMRS: if (tick) begin
                    state     <= S_IDLE;
                    cpu_busy  <= 1'b0;
                    init_done <= 1'b1;
                end
                S_IDLE: begin
                    if (ref_pend) begin
                        cmd     <= C_REF;
                        ref_ack <= 1'b1;
                        cnt     <= CNT_W'(T_RFC - 1);
                        state   <= S_REF;
                    end else if (pend) begin
                        cmd   <= C_ACT;
                        ba    <= loc.bank;
                        a     <= loc.row;
                        pend  <= 1'b0;
                        cnt   <= CNT_W'(T_RCD - 1);
                        state <= S_ACT;
                    end
                end
                S_ACT: if (tick) begin
                    a <= ROW_W'(loc.col);
                    if (req.we) begin
                        cmd   <= C_WR;
                        dq_o  <= req.data[HALF_W-1:0];
                        dq_oe <= 1'b1;
                        state <= S_WR1;
                    end else begin
                        cmd   <= C_RD;
                        cnt   <= CNT_W'(CAS_LAT);
                        state <= S_RD;
                    end
                end
                S_WR1: begin
                    dq_o  <= req.data[WORD_W-1:HALF_W];
                    state <= S_WR2;
                end
                S_WR2: begin
                    dq_oe    <= 1'b0;
                    cpu_busy <= 1'b0;
                    cnt      <= CNT_W'(T_WR - 1);
                    state    <= S_WREC;
                end
                S_WREC: if (tick) begin
                    cmd   <= C_PRE;
                    a     <= '0;
                    cnt   <= CNT_W'(T_RP - 1);
                    state <= S_PRE;
                end
                S_RD: if (tick) begin
                    lo    <= dq_i;
                    state <= S_RD2;
                end
                S_RD2: begin
                    cpu_rdata <= {dq_i, lo};
                    cpu_busy  <= 1'b0;
                    cmd       <= C_PRE;
                    a         <= '0;
                    cnt       <= CNT_W'(T_RP - 1);
                    state     <= S_PRE;
                end
                S_PRE, S_REF: if (tick) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // spacing monitors for the checks below
    logic [CNT_W-1:0] since_act, since_pre;
    localparam logic [CNT_W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= SAT;
            since_pre <= SAT;
        end else begin
            since_act <= (cmd == C_ACT) ? CNT_W'(1) : (since_act == SAT ? SAT : since_act + 1'b1);
            since_pre <= (cmd == C_PRE) ? CNT_W'(1) : (since_pre == SAT ? SAT : since_pre + 1'b1);
        end
    end

    // R1: busy held through initialization
    a_r1_busy_in_init: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> cpu_busy);

    // R4: column command waits for the activate delay
    a_r4_rcd_spacing: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_RD || cmd == C_WR) |-> (since_act >= CNT_W'(T_RCD)));

    // R4: activate waits for the precharge delay
    a_r4_rp_spacing: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_ACT) |-> (since_pre >= CNT_W'(T_RP)));

    // R5: busy drops before the row has been closed
    a_r5_early_release: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_busy) && $past(init_done)) |-> (state == S_WREC || state == S_PRE));

    // R6: an accepted strobe raises busy
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_busy) |=> cpu_busy);

    // R8: due refresh beats a waiting request
    a_r8_refresh_first: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && ref_pend && pend) |=> (cmd == C_REF));

endmodule

// File: rtl/sdram_word_ctrl.sv
module sdram_word_ctrl
    import sdr_pkg::*;
#(
    parameter int T_INIT       = 20,
    parameter int T_RP         = 2,
    parameter int T_RFC        = 4,
    parameter int T_RCD        = 2,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2,
    parameter int INIT_REFS    = 2,
    parameter int REF_INTERVAL = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WA_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_busy,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [1:0]        sd_dqm,
    output logic [HALF_W-1:0] sd_dq_o,
    output logic              sd_dq_oe,
    input  logic [HALF_W-1:0] sd_dq_i
);
    logic     ref_pend, ref_ack, init_done;
    sdr_cmd_e cmd;

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .en      (init_done),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    sdr_cmd_fsm #(
        .T_INIT(T_INIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_RCD(T_RCD),
        .T_WR(T_WR), .T_MRD(T_MRD), .INIT_REFS(INIT_REFS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_busy  (cpu_busy),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .init_done (init_done),
        .cmd       (cmd),
        .ba        (sd_ba),
        .a         (sd_a),
        .dq_o      (sd_dq_o),
        .dq_oe     (sd_dq_oe),
        .dq_i      (sd_dq_i)
    );

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dqm = 2'b00;

endmodule

// File: tb/sdram_word_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_word_ctrl_bench;

    localparam int T_RP = 2, T_RFC = 4, T_RCD = 2, REF_IV = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [22:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        busy;
    logic        ras_n, cas_n, we_n, dq_oe;
    logic [1:0]  ba, dqm;
    logic [12:0] a;
    logic [15:0] dq_o;
    logic [15:0] dq_i = '0;

    always #2.5 clk = ~clk;

    sdram_word_ctrl u_sdram_word_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_busy(busy), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq_o(dq_o), .sd_dq_oe(dq_oe),
        .sd_dq_i(dq_i)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural device model ----------------
    logic [15:0] dmem [int];
    logic [31:0] expm [int];
    bit          open_b [4];
    logic [12:0] orow [4];
    int          act_cyc [4], pre_cyc [4];
    int          cyc = 0, n_ref = 0, n_wr = 0, last_ref = -1;
    bit          mode_ok = 0;
    bit          wr2_v = 0, rd1_v = 0, rd2_v = 0;
    int          wr2_a, rd1_a, rd2_a;
    logic [2:0]  seq_c [4];
    logic [12:0] seq_a [4];
    int          seq_n = 0;

    function automatic logic [15:0] rdh(input int k);
        return dmem.exists(k) ? dmem[k] : 16'h0;
    endfunction

    always @(posedge clk) begin
        logic [2:0] c;
        int         k;
        c = {ras_n, cas_n, we_n};
        if (rst) begin
            seq_n = 0; mode_ok = 0; wr2_v = 0; rd1_v = 0; rd2_v = 0; last_ref = -1;
        end else begin
            cyc++;
            if (wr2_v) begin
                chk(dq_oe && dqm == 2'b00, "R3 second write beat driven, masks low", {dq_oe, dqm}, 3'b100);
                dmem[wr2_a] = dq_o;
                wr2_v = 0;
            end
            if (rd2_v) begin dq_i <= rdh(rd2_a); rd2_v = 0; end
            if (rd1_v) begin dq_i <= rdh(rd1_a); rd2_v = 1; rd2_a = rd1_a + 1; rd1_v = 0; end
            if (c != 3'b111 && seq_n < 4) begin seq_c[seq_n] = c; seq_a[seq_n] = a; seq_n++; end
            k = {ba, orow[ba], a[8:0]};
            case (c)
                3'b011: begin
                    chk(!open_b[ba], "R4 activate to closed bank", open_b[ba], 0);
                    chk(cyc - pre_cyc[ba] >= T_RP, "R4 precharge-to-activate gap", cyc - pre_cyc[ba], T_RP);
                    open_b[ba] = 1; orow[ba] = a; act_cyc[ba] = cyc;
                end
                3'b100: begin
                    chk(open_b[ba] && !a[10] && mode_ok, "R4 write to open row, no auto-precharge", {open_b[ba], a[10]}, 2'b10);
                    chk(cyc - act_cyc[ba] >= T_RCD, "R4 activate-to-write gap", cyc - act_cyc[ba], T_RCD);
                    chk(dq_oe && dqm == 2'b00 && !a[0], "R3 first write beat at even column", {dq_oe, dqm, a[0]}, 4'b1000);
                    dmem[k] = dq_o; wr2_v = 1; wr2_a = k + 1; n_wr++;
                end
                3'b101: begin
                    chk(open_b[ba] && !a[10] && !dq_oe, "R4 read from open row", {open_b[ba], a[10], dq_oe}, 3'b100);
                    chk(cyc - act_cyc[ba] >= T_RCD, "R4 activate-to-read gap", cyc - act_cyc[ba], T_RCD);
                    rd1_v = 1; rd1_a = k;
                end
                3'b010: begin
                    for (int b = 0; b < 4; b++)
                        if (a[10] || b == int'(ba)) begin open_b[b] = 0; pre_cyc[b] = cyc; end
                end
                3'b001: begin
                    chk(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R7 refresh with all banks closed",
                        {open_b[0], open_b[1], open_b[2], open_b[3]}, 0);
                    if (mode_ok && last_ref >= 0)
                        chk(cyc - last_ref <= REF_IV + 20 && cyc - last_ref >= T_RFC,
                            "R8 refresh gap bounded despite requests", cyc - last_ref, REF_IV);
                    if (mode_ok) last_ref = cyc;
                    n_ref++;
                end
                3'b000: mode_ok = (a == 13'h021);
                default: ;
            endcase
        end
    end

    // ---------------- CPU-side tasks ----------------
    task automatic wait_ready(input string tag);
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        if (g >= 5000) chk(0, {tag, " busy never released"}, 1, 0);
    endtask

    task automatic access(input bit we, input logic [22:0] addr, input logic [31:0] data, input bit poke);
        int          key;
        logic [31:0] e;
        wait_ready("R6");
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = data;
        @(negedge clk);
        cpu_req = 0;
        if (poke) begin
            // R6: strobe raised while busy must be dropped
            cpu_req = 1; cpu_we = 1; cpu_addr = addr ^ 23'h000100; cpu_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            cpu_req = 0;
        end
        wait_ready("R5");
        chk(open_b[addr[22:21]] && orow[addr[22:21]] == addr[20:8],
            "R5 busy dropped while row still open", open_b[addr[22:21]], 1);
        key = int'(addr);
        if (we) begin
            expm[key] = data;
            chk(rdh(int'({addr, 1'b0})) == data[15:0] && rdh(int'({addr, 1'b1})) == data[31:16],
                "R2 R3 halves at mapped device locations",
                {rdh(int'({addr, 1'b1})), rdh(int'({addr, 1'b0}))}, data);
        end else begin
            e = expm.exists(key) ? expm[key] : 32'h0;
            chk(cpu_rdata == e, "R10 read returns last written word", cpu_rdata, e);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1 && dq_oe == 1'b0, "R1 busy high, bus released in reset", {busy, dq_oe}, 2'b10);
        rst = 0;
        wait_ready("R1");
        chk(seq_n == 4, "R1 four init commands", seq_n, 4);
        chk(seq_c[0] == 3'b010 && seq_a[0][10], "R1 first command precharge-all", {seq_c[0], seq_a[0][10]}, 4'b0101);
        chk(seq_c[1] == 3'b001 && seq_c[2] == 3'b001, "R1 two auto-refresh", {seq_c[1], seq_c[2]}, 6'b001001);
        chk(seq_c[3] == 3'b000 && seq_a[3] == 13'h021, "R1 mode load 0x021", {seq_c[3], seq_a[3]}, {3'b000, 13'h021});
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int          r0, w0;
        logic [22:0] ad;
        do_reset();
        chk(n_wr == 0, "R9 no writes during initialization", n_wr, 0);

        // distinct patterns and address corners, R2 R3 R10
        access(1, 23'h000000, 32'h0000_0000, 0);
        access(1, 23'h7FFFFF, 32'hFFFF_FFFF, 0);
        access(1, 23'h2AAAAA, 32'hA5A5_5A5A, 0);
        access(1, 23'h1FFFFF, 32'h1234_5678, 0);
        access(1, 23'h200000, 32'h8765_4321, 0);
        access(0, 23'h000000, 0, 0);
        access(0, 23'h7FFFFF, 0, 0);
        access(0, 23'h2AAAAA, 0, 0);
        access(0, 23'h1FFFFF, 0, 0);
        access(0, 23'h200000, 0, 0);

        // R6: strobe during busy is ignored (target word stays zero)
        access(0, 23'h2AAAAA, 0, 1);
        access(0, 23'h2AABAA, 0, 0);

        // R6: request issued in the row-closing tail, same bank and row
        access(1, 23'h155555, 32'hCAFE_F00D, 0);
        chk(open_b[2'b00] == 1'b1, "R6 next request lands in precharge tail", open_b[0], 1);
        access(0, 23'h155555, 0, 0);

        // R7: idle refresh rate
        r0 = n_ref;
        repeat (2000) @(negedge clk);
        chk(n_ref - r0 >= 9 && n_ref - r0 <= 11, "R7 autonomous refresh count", n_ref - r0, 10);

        // R8: back-to-back stream across many refresh intervals
        r0 = n_ref;
        for (int i = 0; i < 240; i++) begin
            ad = 23'(i * 40961) ^ 23'h3C0F0F;
            access(1, ad, 32'(i * 32'h9E37_79B9), 0);
            access(0, ad, 0, 0);
        end
        chk(n_ref - r0 >= 15, "R8 refreshes kept up during traffic", n_ref - r0, 15);

        // R9: contents survive reset
        w0 = n_wr;
        do_reset();
        chk(n_wr == w0, "R9 reset issues no writes", n_wr, w0);
        access(0, 23'h7FFFFF, 0, 0);
        access(0, 23'h1FFFFF, 0, 0);
        access(0, 23'h155555, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule